// File: doc/BRIEF.md
# Serial Control Word Receiver

This block receives 16-bit control words over a write-only three-wire serial link (data, shift clock, latch strobe). It routes each word into one of two on-chip control registers. Data bits enter a shift register most significant bit first, one bit per rising edge of the serial clock. A rising edge on the latch strobe moves the assembled word into a register. The word's lowest bit acts as the address: 0 picks the one-time setup register and 1 picks the operating-mode register. The upper 15 bits become that register's contents.

The serial lines are asynchronous to the system clock. They pass through synchronizer chains, and edge detection turns them into single-cycle strobes. A control module produces the strobes and a datapath module holds the shift register and both control registers. The decoded fields drive the radio's sections directly:
- Setup fields: control-line polarities, divider power policies, band-switch polarity, control-source select, charge-pump test code, slicer enable, S-field mode, detector sense and reference select.
- Mode fields: synthesizer A/M divider values and nine section power enables.

Register contents are held until the next write to the same register. Nothing else touches them.

Top module: `serCtrlPort`

## Requirements
- R1: After reset every field output is 0 and `setupLoaded` is 0.
- R2: Each rising edge of `serClk` shifts `serData` into a 16-bit shift register at the least significant end. The earliest bit of a word therefore ends up as D15.
- R3: A rising edge of `serLatch` with D0=0 in the shift register loads D15..D1 into the setup register and leaves every mode field unchanged.
- R4: A rising edge of `serLatch` with D0=1 loads D15..D1 into the mode register and leaves every setup field unchanged.
- R5: Setup field positions are fixed. D15 is stored but not decoded. D14 is `rxSense`, D13 is `txSense` and D12 is `synSense`. D11:D10 form `rxDivMode`. D9 is `txDivMode`, D8 is `bandSense`, D7 is `pinCtrlSel`, and D6:D5 form `pumpTest`. D4 is `slicerEn`, D3 is `sFieldMode`, D2 is `pfdSense` and D1 is `refSel`.
- R6: Mode field positions are fixed. D15:D11 form `aCount`. D10 is `mSel`. D9..D1 form `pwrEn[8:0]`, with D9 at `pwrEn[8]`.
- R7: `setupLoaded` rises on the first setup-register load and then stays high. Mode-register loads do not set it.
- R8: A word shifted with more or fewer than 16 clock edges before the latch edge loads the last 16 bits shifted in. When fewer than 16 bits arrive, the remaining bits come from earlier traffic.
- R9: Serial clock edges without a latch edge change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial shift clock (asynchronous) |
| serData | input | 1 | Serial data, MSB first |
| serLatch | input | 1 | Latch strobe; rising edge loads a register |
| rxSense | output | 1 | Receive control-line polarity |
| txSense | output | 1 | Transmit control-line polarity |
| synSense | output | 1 | Synthesizer control-line polarity |
| rxDivMode | output | 2 | Divider power policy in receive slot |
| txDivMode | output | 1 | Divider power policy in transmit slot |
| bandSense | output | 1 | Band-switch polarity |
| pinCtrlSel | output | 1 | 1 = section control from external lines |
| pumpTest | output | 2 | Charge-pump test code |
| slicerEn | output | 1 | Data slicer enable |
| sFieldMode | output | 1 | S-field demodulation mode |
| pfdSense | output | 1 | Phase detector sense |
| refSel | output | 1 | Reference frequency select |
| setupLoaded | output | 1 | Setup register has been written |
| aCount | output | 5 | Synthesizer A counter value |
| mSel | output | 1 | M divide ratio select |
| pwrEn | output | 9 | Section power enables |

## Verification
The bench uses the default two-stage synchronizer and holds each serial phase for four system clocks. At that pacing every edge is seen exactly once, so expected register contents follow from a bit-level model of the shift register. Every A/M combination (64 mode words) is swept with varied power-enable patterns. Each setup bit is walked on its own. Over- and under-length words reach the history-dependent loads of R8.

// File: rtl/serCtrlPkg.sv
package serCtrlPkg;
  localparam int WORD_W = 16;
  localparam int DATA_W = WORD_W - 1;

  typedef struct packed {
    logic shiftPulse;
    logic shiftBit;
    logic latchPulse;
  } serStrobe_t;

  typedef struct packed {
    logic       rxSense;
    logic       txSense;
    logic       synSense;
    logic [1:0] rxDivMode;
    logic       txDivMode;
    logic       bandSense;
    logic       pinCtrlSel;
    logic [1:0] pumpTest;
    logic       slicerEn;
    logic       sFieldMode;
    logic       pfdSense;
    logic       refSel;
  } setupFields_t;

  typedef struct packed {
    logic [4:0] aCount;
    logic       mSel;
    logic [8:0] pwrEn;
  } modeFields_t;

  localparam int SETUP_FIELD_W = $bits(setupFields_t);
  localparam int MODE_FIELD_W  = $bits(modeFields_t);
endpackage

// File: rtl/serCtrlSync.sv
module serCtrlSync
  import serCtrlPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serClk,
  input  logic       serData,
  input  logic       serLatch,
  output serStrobe_t strb
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] clkSync;
  logic [TOP:0] dataSync;
  logic [TOP:0] latchSync;
  logic         clkPrev;
  logic         latchPrev;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          clkSync   <= '0;
          dataSync  <= '0;
          latchSync <= '0;
        end else begin
          clkSync   <= serClk;
          dataSync  <= serData;
          latchSync <= serLatch;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          clkSync   <= '0;
          dataSync  <= '0;
          latchSync <= '0;
        end else begin
          clkSync   <= {clkSync[TOP-1:0], serClk};
          dataSync  <= {dataSync[TOP-1:0], serData};
          latchSync <= {latchSync[TOP-1:0], serLatch};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev   <= 1'b0;
      latchPrev <= 1'b0;
      strb      <= '0;
    end else begin
      clkPrev         <= clkSync[TOP];
      latchPrev       <= latchSync[TOP];
      strb.shiftPulse <= clkSync[TOP] & ~clkPrev;
      strb.shiftBit   <= dataSync[TOP];
      strb.latchPulse <= latchSync[TOP] & ~latchPrev;
    end
  end

  AST_SHIFT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftPulse |=> !strb.shiftPulse); // R2
  AST_LATCH_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchPulse |=> !strb.latchPulse); // R3
endmodule

// File: rtl/serCtrlRegs.sv
module serCtrlRegs
  import serCtrlPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  serStrobe_t   strb,
  output setupFields_t setupF,
  output modeFields_t  modeF,
  output logic         setupLoaded
);
  logic [WORD_W-1:0] shiftReg;
  logic [DATA_W-1:0] setupReg;
  logic [DATA_W-1:0] modeReg;
  logic              toMode;
  logic              toSetup;

  assign toMode  = strb.latchPulse &  shiftReg[0];
  assign toSetup = strb.latchPulse & ~shiftReg[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strb.shiftPulse) begin
      shiftReg <= {shiftReg[WORD_W-2:0], strb.shiftBit};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      setupReg    <= '0;
      modeReg     <= '0;
      setupLoaded <= 1'b0;
    end else begin
      if (toMode) begin
        modeReg <= shiftReg[WORD_W-1:1];
      end
      if (toSetup) begin
        setupReg    <= shiftReg[WORD_W-1:1];
        setupLoaded <= 1'b1;
      end
    end
  end

  assign setupF = setupFields_t'(setupReg[SETUP_FIELD_W-1:0]);
  assign modeF  = modeFields_t'(modeReg[MODE_FIELD_W-1:0]);

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !toMode |=> $stable(modeReg)); // R9
  AST_SETUP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !toSetup |=> $stable(setupReg)); // R9
  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    toMode |=> modeReg == $past(shiftReg[WORD_W-1:1])); // R4
  AST_SETUP_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    toSetup |=> setupReg == $past(shiftReg[WORD_W-1:1])); // R3
  AST_LOADED_SET: assert property (@(posedge clk) disable iff (!rstN)
    toSetup |=> setupLoaded); // R7
  AST_LOADED_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    setupLoaded |=> setupLoaded); // R7
endmodule

// File: rtl/serCtrlPort.sv
module serCtrlPort
  import serCtrlPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serClk,
  input  logic       serData,
  input  logic       serLatch,
  output logic       rxSense,
  output logic       txSense,
  output logic       synSense,
  output logic [1:0] rxDivMode,
  output logic       txDivMode,
  output logic       bandSense,
  output logic       pinCtrlSel,
  output logic [1:0] pumpTest,
  output logic       slicerEn,
  output logic       sFieldMode,
  output logic       pfdSense,
  output logic       refSel,
  output logic       setupLoaded,
  output logic [4:0] aCount,
  output logic       mSel,
  output logic [8:0] pwrEn
);
  serStrobe_t   strb;
  setupFields_t setupF;
  modeFields_t  modeF;

  serCtrlSync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rstN     (rstN),
    .serClk   (serClk),
    .serData  (serData),
    .serLatch (serLatch),
    .strb     (strb)
  );

  serCtrlRegs u_regs (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .setupF      (setupF),
    .modeF       (modeF),
    .setupLoaded (setupLoaded)
  );

  assign rxSense    = setupF.rxSense;
  assign txSense    = setupF.txSense;
  assign synSense   = setupF.synSense;
  assign rxDivMode  = setupF.rxDivMode;
  assign txDivMode  = setupF.txDivMode;
  assign bandSense  = setupF.bandSense;
  assign pinCtrlSel = setupF.pinCtrlSel;
  assign pumpTest   = setupF.pumpTest;
  assign slicerEn   = setupF.slicerEn;
  assign sFieldMode = setupF.sFieldMode;
  assign pfdSense   = setupF.pfdSense;
  assign refSel     = setupF.refSel;
  assign aCount     = modeF.aCount;
  assign mSel       = modeF.mSel;
  assign pwrEn      = modeF.pwrEn;
endmodule

// File: tb/serCtrlPort_tb.sv
module serCtrlPort_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0;
  logic serData = 1'b0;
  logic serLatch = 1'b0;
  logic rxSense, txSense, synSense, txDivMode, bandSense, pinCtrlSel;
  logic slicerEn, sFieldMode, pfdSense, refSel, setupLoaded, mSel;
  logic [1:0] rxDivMode, pumpTest;
  logic [4:0] aCount;
  logic [8:0] pwrEn;

  int nChecks = 0;
  int nFail = 0;
  logic [15:0] shModel = '0;
  logic [14:0] expSetup = '0;
  logic [14:0] expMode = '0;
  logic expLoaded = 1'b0;

  always #10 clk = ~clk;

  serCtrlPort u_dut (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData), .serLatch(serLatch),
    .rxSense(rxSense), .txSense(txSense), .synSense(synSense), .rxDivMode(rxDivMode),
    .txDivMode(txDivMode), .bandSense(bandSense), .pinCtrlSel(pinCtrlSel),
    .pumpTest(pumpTest), .slicerEn(slicerEn), .sFieldMode(sFieldMode),
    .pfdSense(pfdSense), .refSel(refSel), .setupLoaded(setupLoaded),
    .aCount(aCount), .mSel(mSel), .pwrEn(pwrEn)
  );

  function automatic logic [13:0] actSetup();
    return {rxSense, txSense, synSense, rxDivMode, txDivMode, bandSense, pinCtrlSel,
            pumpTest, slicerEn, sFieldMode, pfdSense, refSel};
  endfunction

  function automatic logic [14:0] actMode();
    return {aCount, mSel, pwrEn};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkAll(input string reqS, input string reqM, input string reqL);
    check(reqS, 32'(actSetup()), 32'(expSetup[13:0]));
    check(reqM, 32'(actMode()), 32'(expMode));
    check(reqL, 32'(setupLoaded), 32'(expLoaded));
  endtask

  task automatic sendBits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      serData = v[i];
      repeat (4) @(negedge clk);
      serClk = 1'b1;
      repeat (4) @(negedge clk);
      serClk = 1'b0;
      shModel = {shModel[14:0], v[i]};
    end
  endtask

  task automatic pulseLatch();
    serLatch = 1'b1;
    repeat (4) @(negedge clk);
    serLatch = 1'b0;
    repeat (6) @(negedge clk);
    if (shModel[0]) expMode = shModel[15:1];
    else begin
      expSetup = shModel[15:1];
      expLoaded = 1'b1;
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog R2 actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    checkAll("R1", "R1", "R1");

    // R7: mode write first must not set setupLoaded
    sendBits(32'h0000_8AB3, 16);
    pulseLatch();
    checkAll("R4", "R6", "R7");

    // R5 / R3: walking setup bits
    for (int b = 1; b < 16; b++) begin
      sendBits(32'(1 << b), 16);
      pulseLatch();
      checkAll("R5", "R3", "R7");
    end
    sendBits(32'h0000_7FFE, 16);
    pulseLatch();
    checkAll("R5", "R3", "R7");

    // R6 / R4: all A and M combinations
    for (int a = 0; a < 32; a++) begin
      for (int m = 0; m < 2; m++) begin
        logic [8:0] p;
        p = 9'((a * 37 + m * 101 + 5) & 9'h1FF);
        sendBits(32'({5'(a), 1'(m), p, 1'b1}), 16);
        pulseLatch();
        checkAll("R4", "R6", "R7");
      end
    end

    // R9: shifting without latch changes nothing
    sendBits(32'h0000_5A5A, 16);
    repeat (6) @(negedge clk);
    checkAll("R9", "R9", "R9");

    // R8: over-length word
    sendBits(32'h000A_3C4B, 20);
    pulseLatch();
    checkAll("R8", "R8", "R8");

    // R8: under-length word mixes in earlier bits
    sendBits(32'h0000_0026, 7);
    pulseLatch();
    checkAll("R8", "R8", "R8");

    // R2: MSB-first order, distinct pattern to setup
    sendBits(32'h0000_C35A, 16);
    pulseLatch();
    checkAll("R2", "R2", "R2");

    finishRun();
  end
endmodule